// File: doc/BRIEF.md
# Four-Event Timestamp Capture Unit

This unit stamps the moments at which a single input signal changes. A 32-bit counter advances by one every clock. Each qualified edge of the input, after an optional divide-by-2N prescaler, is treated as the next of four capture events. Events are taken in strict rotation. At each event the current counter value is copied into that event's capture register, and a one-cycle pulse is raised on that event's pulse bit.

Each event has its own edge polarity. Each event can also clear the counter once its stamp is taken. With no clears the registers hold absolute times; with clears they hold intervals between events. All settings come from one 16-bit control word. A debug-halt input can freeze the counter at once, let it run on until it wraps to zero, or be ignored.

Top module: `cap4_stamp`

## Requirements
- R1: After reset the control word is 0, every capture register reads 0, no pulse is raised, and the first event goes to event 1 (stamp0, pulse bit 0).
- R2: When the counter is not halted and no event clears it, it advances by exactly one per clock. In absolute mode, the difference between two consecutive stamps therefore equals the number of clocks between the two input edges.
- R3: Control bit 2k (k = 0..3, for events 1..4) selects the event's edge: 0 means rising, 1 means falling.
- R4: Events rotate 1,2,3,4,1. Event k raises only pulse bit k-1, for one clock, and stores into stampk-1.
- R5: Control bit 2k+1 set to 1 makes event k+1 clear the counter after its value is stored. The counter then reads 0 on the next clock, so the next stamp equals the clock count between the edges minus one.
- R6: Control bit 8 enables capture-register loads. When it is 0 the registers keep their values, but pulses are still raised.
- R7: Control bits 13:9 hold the prescale code N. With N = 0 the synchronized input is used directly. With N > 0 the prescaled signal starts low and toggles after every N rising edges of the input, which divides the input by 2N.
- R8: A control write that changes the prescale code clears the prescaler's edge count and sets its output low.
- R9: With control bits 15:14 = 0, the counter holds its value on every clock at which debug-halt is high.
- R10: With control bits 15:14 = 1, a halted counter keeps counting while it is nonzero and holds once it reads zero.
- R11: With control bits 15:14 = 2 or 3, debug-halt has no effect on the counter.
- R12: With the prescaler bypassed, an input edge set up before clock edge 1 is stamped at clock edge 3. The pulse is high after edge 3 and low after edges 1 and 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_we | input | 1 | Writes ctrl_wdata into the control word |
| ctrl_wdata | input | 16 | Control word write data |
| sig_in | input | 1 | Asynchronous input whose edges are stamped |
| dbg_halt | input | 1 | Debug halt request for the counter |
| stamp0 | output | 32 | Capture register of event 1 |
| stamp1 | output | 32 | Capture register of event 2 |
| stamp2 | output | 32 | Capture register of event 3 |
| stamp3 | output | 32 | Capture register of event 4 |
| evt_pulse | output | 4 | One-clock pulse per event, bit k-1 for event k |

## Verification
The properties check on every cycle that:
- pulses are one-hot and match the rotation;
- the registers hold still while loads are disabled;
- the counter steps, clears and freezes as each halt mode and reset bit requires.

Only the bench scenarios can show the end-to-end results. These are the stamp differences for random edge spacing, falling-edge selection, the divide ratio, the prescaler restart on a code change, and the three-clock capture latency.

// File: rtl/cap4_stamp.sv
module cap4_stamp #(
  parameter int CW = 32,
  parameter int PW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ctrl_we,
  input  logic [15:0]   ctrl_wdata,
  input  logic          sig_in,
  input  logic          dbg_halt,
  output logic [CW-1:0] stamp0,
  output logic [CW-1:0] stamp1,
  output logic [CW-1:0] stamp2,
  output logic [CW-1:0] stamp3,
  output logic [3:0]    evt_pulse
);
  logic [15:0]         ctrl_q;
  logic                s_meta, s_sync, s_prev;
  logic [PW-1:0]       pre_cnt;
  logic                pre_tog, pre_d;
  logic [1:0]          seq;
  logic [CW-1:0]       cnt;
  logic [3:0][CW-1:0]  stamp_q;

  wire [PW-1:0] div    = ctrl_q[9 +: PW];
  wire [1:0]    hmode  = ctrl_q[15:14];
  wire          lden   = ctrl_q[8];
  wire          s_rise = s_sync & ~s_prev;
  wire          pre_out = (div == '0) ? s_sync : pre_tog;
  wire          e_rise = pre_out & ~pre_d;
  wire          e_fall = ~pre_out & pre_d;
  wire          hit    = ctrl_q[{seq, 1'b0}] ? e_fall : e_rise;
  wire          clr    = hit & ctrl_q[{seq, 1'b1}];
  wire          run    = hmode[1] | ~dbg_halt | (hmode == 2'd1 && cnt != '0);

  assign stamp0 = stamp_q[0];
  assign stamp1 = stamp_q[1];
  assign stamp2 = stamp_q[2];
  assign stamp3 = stamp_q[3];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) ctrl_q <= '0;
    else if (ctrl_we) ctrl_q <= ctrl_wdata;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) {s_meta, s_sync, s_prev} <= '0;
    else {s_meta, s_sync, s_prev} <= {sig_in, s_meta, s_sync};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pre_cnt <= '0;
      pre_tog <= 1'b0;
    end else if (ctrl_we && ctrl_wdata[9 +: PW] != div) begin
      pre_cnt <= '0;
      pre_tog <= 1'b0;
    end else if (div != '0 && s_rise) begin
      if (pre_cnt == div - PW'(1)) begin
        pre_cnt <= '0;
        pre_tog <= ~pre_tog;
      end else begin
        pre_cnt <= pre_cnt + PW'(1);
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) pre_d <= 1'b0;
    else pre_d <= pre_out;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) cnt <= '0;
    else if (clr) cnt <= '0;
    else if (run) cnt <= cnt + CW'(1);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      seq       <= 2'd0;
      stamp_q   <= '0;
      evt_pulse <= 4'b0;
    end else begin
      seq       <= seq + {1'b0, hit};
      evt_pulse <= hit ? (4'b1 << seq) : 4'b0;
      if (hit && lden) stamp_q[seq] <= cnt;
    end
endmodule

// File: rtl/cap4_stamp_chk.sv
module cap4_stamp_chk #(
  parameter int CW = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic [15:0]        ctrl,
  input logic               halt,
  input logic               hit,
  input logic [1:0]         seq,
  input logic [CW-1:0]      cnt,
  input logic [3:0]         pulse,
  input logic [3:0][CW-1:0] stamps
);
  AST_PULSE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pulse)); // R4
  AST_PULSE_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    (|pulse) |-> pulse == (4'b1 << (seq - 2'd1))); // R4
  AST_NOLOAD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl[8] |=> $stable(stamps)); // R6
  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (!halt && !hit) |=> cnt == $past(cnt) + CW'(1)); // R2
  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && ctrl[{seq, 1'b1}]) |=> cnt == '0); // R5
  AST_HALT_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl[15:14] == 2'd0 && halt && !hit) |=> $stable(cnt)); // R9
  AST_HALT_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl[15:14] == 2'd1 && halt && cnt == '0 && !hit) |=> cnt == '0); // R10
  AST_HALT_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl[15:14] == 2'd1 && cnt != '0 && !hit) |=> cnt == $past(cnt) + CW'(1)); // R10
  AST_HALT_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl[15] && !hit) |=> cnt == $past(cnt) + CW'(1)); // R11
endmodule

bind cap4_stamp cap4_stamp_chk #(.CW(CW)) chk_i (
  .clk(clk), .rst_n(rst_n), .ctrl(ctrl_q), .halt(dbg_halt), .hit(hit),
  .seq(seq), .cnt(cnt), .pulse(evt_pulse), .stamps(stamp_q)
);

// File: tb/cap4_stamp_tb_top.sv
`timescale 1ns/1ps
module cap4_stamp_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctrl_we = 1'b0;
  logic [15:0] ctrl_wdata = '0;
  logic        sig_in = 1'b0;
  logic        dbg_halt = 1'b0;
  logic [31:0] stamp0, stamp1, stamp2, stamp3;
  logic [3:0]  evt_pulse;
  int nchk = 0, nerr = 0;
  int pc [4] = '{0, 0, 0, 0};

  always #2 clk = ~clk;

  cap4_stamp dut_i (
    .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
    .sig_in(sig_in), .dbg_halt(dbg_halt), .stamp0(stamp0), .stamp1(stamp1),
    .stamp2(stamp2), .stamp3(stamp3), .evt_pulse(evt_pulse)
  );

  always @(posedge clk) begin
    #1;
    for (int k = 0; k < 4; k++) if (evt_pulse[k]) pc[k]++;
  end

  function automatic logic [31:0] stp(input int s);
    case (s)
      0: return stamp0;
      1: return stamp1;
      2: return stamp2;
      default: return stamp3;
    endcase
  endfunction

  function automatic int exp_slot(input int n);
    return n % 4;
  endfunction

  function automatic logic [31:0] exp_delta(input int gap, input bit cleared);
    return cleared ? 32'(gap - 1) : 32'(gap);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; sig_in = 1'b0; dbg_halt = 1'b0; ctrl_we = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic wr(input logic [15:0] v);
    ctrl_we = 1'b1; ctrl_wdata = v;
    @(negedge clk);
    ctrl_we = 1'b0;
  endtask

  task automatic rise_evt(input int gap, input int slot);
    sig_in = 1'b1;
    repeat (2) @(negedge clk);
    chk("R12 latency", 32'(evt_pulse), 32'h0);
    @(negedge clk);
    chk("R4 pulse", 32'(evt_pulse), 32'(4'b1 << slot));
    sig_in = 1'b0;
    repeat (gap - 3) @(negedge clk);
  endtask

  task automatic in_cycle(input int hi, input int lo);
    sig_in = 1'b1;
    repeat (hi) @(negedge clk);
    sig_in = 1'b0;
    repeat (lo) @(negedge clk);
  endtask

  task automatic halt_case(input logic [15:0] c, input bit absol, input logic [31:0] want, input string req);
    do_reset();
    wr(c);
    sig_in = 1'b1;
    repeat (3) @(negedge clk);
    sig_in = 1'b0;
    dbg_halt = 1'b1;
    repeat (10) @(negedge clk);
    dbg_halt = 1'b0;
    repeat (7) @(negedge clk);
    sig_in = 1'b1;
    repeat (3) @(negedge clk);
    sig_in = 1'b0;
    chk(req, absol ? stamp1 : stamp1 - stamp0, want);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

  initial begin
    int gap, prev_gap, b0, b1;
    void'($urandom(32'd4242));
    do_reset();
    chk("R1 stamp0", stamp0, 0);
    chk("R1 stamp3", stamp3, 0);
    chk("R1 pulse", 32'(evt_pulse), 0);

    wr(16'h0100);
    prev_gap = 0;
    for (int n = 0; n < 13; n++) begin
      gap = (n < 5) ? 16 : int'($urandom_range(40, 6));
      rise_evt(gap, exp_slot(n));
      if (n > 0) chk("R2 delta", stp(exp_slot(n)) - stp(exp_slot(n - 1)), exp_delta(prev_gap, 1'b0));
      prev_gap = gap;
    end

    do_reset();
    wr(16'h0104);
    sig_in = 1'b1;
    repeat (5) @(negedge clk);
    sig_in = 1'b0;
    repeat (3) @(negedge clk);
    chk("R3 fall pulse", 32'(evt_pulse), 32'h2);
    chk("R3 fall delta", stamp1 - stamp0, 5);

    do_reset();
    wr(16'h0102);
    rise_evt(16, 0);
    rise_evt(16, 1);
    chk("R5 cleared stamp", stamp1, exp_delta(16, 1'b1));

    do_reset();
    wr(16'h0000);
    rise_evt(8, 0);
    chk("R6 no load", stamp0, 0);

    do_reset();
    wr(16'h0500);
    b0 = pc[0]; b1 = pc[1];
    for (int i = 0; i < 8; i++) in_cycle(4, 4);
    repeat (6) @(negedge clk);
    chk("R7 ev1 count", 32'(pc[0] - b0), 1);
    chk("R7 ev2 count", 32'(pc[1] - b1), 1);
    chk("R7 divide", stamp1 - stamp0, 32);

    do_reset();
    wr(16'h0500);
    b0 = pc[0];
    in_cycle(4, 4);
    wr(16'h0700);
    wr(16'h0500);
    in_cycle(4, 4);
    repeat (6) @(negedge clk);
    chk("R8 restart", 32'(pc[0] - b0), 0);
    in_cycle(4, 4);
    repeat (6) @(negedge clk);
    chk("R8 after restart", 32'(pc[0] - b0), 1);

    halt_case(16'h0100, 1'b0, 10, "R9 freeze");
    halt_case(16'h4100, 1'b0, 20, "R10 nonzero");
    halt_case(16'h4102, 1'b1, 9, "R10 at zero");
    halt_case(16'h8100, 1'b0, 20, "R11 mode2");
    halt_case(16'hC100, 1'b0, 20, "R11 mode3");

    $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule